// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address order for a single read or write burst inside a double-data-rate memory controller. A start pulse captures three things: a starting column address, a burst length code (2, 4 or 8 beats) and an ordering mode. The ordering mode is either wrapping-sequential or interleaved. After that, each cycle with the step enable high emits one column address, together with a valid flag. On the final beat of the burst a last flag is also raised.

The low column bits that pick the beat inside the aligned burst block follow the chosen order. In sequential mode the position counts upward and wraps inside the block. In interleaved mode the position is the beat index XOR the starting position. The bits above the block are copied from the starting address and never receive a carry. Length and mode are frozen for the whole burst. A start pulse that arrives while a burst is running is dropped.

Top module: `burst_col_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it is released, `valid_o`, `last_o` and `busy_o` are 0.
- R2: A `start_i` pulse seen at a rising edge while idle captures `start_col_i`, `blen_i` and `ilv_i`. `busy_o` is 1 from that edge on.
- R3: Length encoding of `blen_i`: 0 gives 2 beats, 1 gives 4 beats, and 2 or 3 give 8 beats. `last_o` is 1 exactly on the final beat (beat index length−1) and is never 1 without `valid_o`.
- R4: With `ilv_i`=0 (sequential), the low log2(length) bits of beat k equal (starting low bits + k) modulo length.
- R5: With `ilv_i`=1 (interleaved), the low log2(length) bits of beat k equal the starting low bits XOR k.
- R6: Every column bit at or above position log2(length) equals the same bit of the captured starting address on every beat. No carry reaches those bits when the order wraps.
- R7: When `step_i` is 1 at a rising edge while busy, `col_o`, `valid_o`=1 and `last_o` for the next beat appear at that edge. When `step_i` is 0, `valid_o` is 0 after the edge and the beat position does not advance.
- R8: A `start_i` pulse while busy is ignored: the running burst's addresses do not change.
- R9: At the edge that emits the final beat, `busy_o` returns to 0, and a new start is accepted at the next edge.
- R10: Changes to `blen_i` or `ilv_i` during a burst have no effect on its length, order or addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse for a new burst |
| start_col_i | input | COL_W | Starting column address |
| blen_i | input | 2 | Burst length code (0:2, 1:4, 2/3:8) |
| ilv_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| step_i | input | 1 | Beat enable; one address per high cycle while busy |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | `col_o` holds a fresh beat this cycle |
| last_o | output | 1 | Current beat is the final one of the burst |
| busy_o | output | 1 | A burst is in progress |

## Verification
`busy_o` becomes 1 at the rising edge that samples the start pulse. Each beat's `col_o`, `valid_o` and `last_o` appear at the rising edge where `step_i` is high, so every result is due exactly one edge after its stimulus. The bench drives inputs on the falling edge and reads the outputs on the next falling edge. This keeps each check half a period clear of the edge that produced it. During every burst the bench also toggles the length and mode inputs, pulses start with a different address, and inserts stall cycles. The expected addresses for all four length codes, both orders, all eight starting offsets and two upper-bit patterns are computed arithmetically.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  localparam int unsigned BEAT_W = 3;

  typedef enum logic [1:0] {
    BL_TWO   = 2'd0,
    BL_FOUR  = 2'd1,
    BL_EIGHT = 2'd2,
    BL_EIGHX = 2'd3
  } blen_e;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } ord_e;

  typedef struct packed {
    logic [BEAT_W-1:0] mask;
    ord_e              ord;
  } burst_cfg_t;

  function automatic logic [BEAT_W-1:0] mask_of(input logic [1:0] code);
    case (blen_e'(code))
      BL_TWO:  mask_of = 3'b001;
      BL_FOUR: mask_of = 3'b011;
      default: mask_of = 3'b111;
    endcase
  endfunction
endpackage

// File: rtl/bsq_ctrl.sv
module bsq_ctrl
  import bsq_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic [1:0]        blen_i,
  input  logic              ilv_i,
  input  logic              step_i,
  output logic              busy_o,
  output burst_cfg_t        cfg_o,
  output logic [COL_W-1:0]  base_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic              fire_o,
  output logic              final_o
);
  logic              busy_q;
  burst_cfg_t        cfg_q;
  logic [COL_W-1:0]  base_q;
  logic [BEAT_W-1:0] beat_q;
  logic              fire;
  logic              fin;

  assign fire = busy_q & step_i;
  assign fin  = fire & (beat_q == cfg_q.mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cfg_q  <= '0;
      base_q <= '0;
      beat_q <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q     <= 1'b1;
        cfg_q.mask <= mask_of(blen_i);
        cfg_q.ord  <= ord_e'(ilv_i);
        base_q     <= start_col_i;
        beat_q     <= '0;
      end
    end else if (fire) begin
      if (fin) begin
        busy_q <= 1'b0;
        beat_q <= '0;
      end else begin
        beat_q <= beat_q + 3'd1;
      end
    end
  end

  assign busy_o  = busy_q;
  assign cfg_o   = cfg_q;
  assign base_o  = base_q;
  assign beat_o  = beat_q;
  assign fire_o  = fire;
  assign final_o = fin;

  assert_beat_advance_R7: assert property (@(posedge clk) disable iff (rst)
    (fire && !fin) |=> (beat_q == $past(beat_q) + 3'd1));
  assert_stall_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !step_i) |=> $stable(beat_q));
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> $stable(base_q));
  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> $stable(cfg_q));
  assert_idle_after_last_R9: assert property (@(posedge clk) disable iff (rst)
    fin |=> !busy_q);
endmodule

// File: rtl/bsq_addr_gen.sv
module bsq_addr_gen
  import bsq_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0]  base_i,
  input  burst_cfg_t        cfg_i,
  input  logic [BEAT_W-1:0] beat_i,
  output logic [COL_W-1:0]  col_o
);
  logic [BEAT_W-1:0] seq_pos;
  logic [BEAT_W-1:0] ilv_pos;
  logic [BEAT_W-1:0] pos;

  // carries only travel upward, so the bits inside the mask wrap by themselves
  assign seq_pos = base_i[BEAT_W-1:0] + beat_i;
  assign ilv_pos = base_i[BEAT_W-1:0] ^ beat_i;
  assign pos     = (cfg_i.ord == ORD_ILV) ? ilv_pos : seq_pos;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    if (b < BEAT_W) begin : g_low
      assign col_o[b] = cfg_i.mask[b] ? pos[b] : base_i[b];
    end else begin : g_high
      assign col_o[b] = base_i[b];
    end
  end
endmodule

// File: rtl/bsq_out_reg.sv
module bsq_out_reg
  import bsq_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire_i,
  input  logic              final_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [COL_W-1:0]  base_i,
  input  logic [BEAT_W-1:0] mask_i,
  output logic [COL_W-1:0]  col_o,
  output logic              valid_o,
  output logic              last_o
);
  logic [COL_W-1:0] col_q;
  logic             valid_q;
  logic             last_q;
  logic [COL_W-1:0] keep_mask;

  assign keep_mask = ~{{(COL_W-BEAT_W){1'b0}}, mask_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q   <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      valid_q <= fire_i;
      last_q  <= final_i;
      if (fire_i) col_q <= col_i;
    end
  end

  assign col_o   = col_q;
  assign valid_o = valid_q;
  assign last_o  = last_q;

  assert_last_has_valid_R3: assert property (@(posedge clk) disable iff (rst)
    last_q |-> valid_q);
  assert_upper_passthru_R6: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> ((col_q & keep_mask) == (base_i & keep_mask)));
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bsq_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [1:0]       blen_i,
  input  logic             ilv_i,
  input  logic             step_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o,
  output logic             busy_o
);
  burst_cfg_t        cfg;
  logic [COL_W-1:0]  base;
  logic [BEAT_W-1:0] beat;
  logic              fire;
  logic              fin;
  logic [COL_W-1:0]  col_next;

  bsq_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
    .blen_i(blen_i), .ilv_i(ilv_i), .step_i(step_i), .busy_o(busy_o),
    .cfg_o(cfg), .base_o(base), .beat_o(beat), .fire_o(fire), .final_o(fin)
  );

  bsq_addr_gen #(.COL_W(COL_W)) u_gen (
    .base_i(base), .cfg_i(cfg), .beat_i(beat), .col_o(col_next)
  );

  bsq_out_reg #(.COL_W(COL_W)) u_out (
    .clk(clk), .rst(rst), .fire_i(fire), .final_i(fin), .col_i(col_next),
    .base_i(base), .mask_i(cfg.mask), .col_o(col_o), .valid_o(valid_o),
    .last_o(last_o)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!valid_o && !last_o && !busy_o));
endmodule

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;
  localparam int COL_W = 10;
  localparam time CLK_PERIOD = 10ns;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [1:0]       blen_i = '0;
  logic             ilv_i = 1'b0;
  logic             step_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o;
  logic             last_o;
  logic             busy_o;

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  burst_col_seq #(.COL_W(COL_W)) i_burst_col_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
    .blen_i(blen_i), .ilv_i(ilv_i), .step_i(step_i), .col_o(col_o),
    .valid_o(valid_o), .last_o(last_o), .busy_o(busy_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_burst(input int code, input bit ilv, input logic [COL_W-1:0] s,
                           input bit stalls);
    int len;
    logic [COL_W-1:0] msk;
    logic [COL_W-1:0] lo;
    logic [COL_W-1:0] exp;
    len = (code == 0) ? 2 : (code == 1) ? 4 : 8;
    msk = COL_W'(len - 1);
    @(negedge clk);
    start_i = 1'b1; start_col_i = s; blen_i = 2'(code); ilv_i = ilv; step_i = 1'b0;
    @(negedge clk);
    chk("R2 busy after start", 32'(busy_o), 32'd1);
    for (int k = 0; k < len; k++) begin
      // disturb config and pulse start mid-burst: R8, R10
      blen_i = 2'(code + 1 + k);
      ilv_i = ~ilv;
      start_i = 1'b1;
      start_col_i = ~s;
      if (stalls && (k % 2 == 1)) begin
        step_i = 1'b0;
        @(negedge clk);
        chk("R7 no valid when stalled", 32'(valid_o), 32'd0);
      end
      step_i = 1'b1;
      @(negedge clk);
      lo  = ilv ? ((s & msk) ^ COL_W'(k)) : ((s + COL_W'(k)) & msk);
      exp = (s & ~msk) | lo;
      chk(ilv ? "R5 R6 R8 R10 interleaved col" : "R4 R6 R8 R10 sequential col",
          32'(col_o), 32'(exp));
      chk("R7 valid on step", 32'(valid_o), 32'd1);
      chk("R3 last flag", 32'(last_o), 32'(k == len - 1));
      step_i = 1'b0;
      start_i = 1'b0;
    end
    chk("R9 idle after last", 32'(busy_o), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 32'(valid_o), 32'd0);
    chk("R1 busy in reset", 32'(busy_o), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after reset", 32'(valid_o), 32'd0);
    chk("R1 last after reset", 32'(last_o), 32'd0);
    chk("R1 busy after reset", 32'(busy_o), 32'd0);
    for (int code = 0; code < 4; code++)
      for (int t = 0; t < 2; t++)
        for (int up = 0; up < 2; up++)
          for (int lo = 0; lo < 8; lo++)
            run_burst(code, t[0], (up != 0 ? 10'h3f8 : 10'h158) | 10'(lo),
                      ((lo + code) % 3) == 0);
    // back-to-back start right after a last beat: R9
    run_burst(2, 1'b0, 10'h3ff, 1'b0);
    run_burst(1, 1'b1, 10'h003, 1'b1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=finish", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule